// File: doc/BRIEF.md
# Threshold-Interval Symmetric Function Unit

This block evaluates Boolean functions that depend only on how many of its N inputs are high. It does this in two levels of logic. The first level is a bank of registered threshold detectors. Detector k answers "are at least k inputs high?" and carries both polarities of that answer. The second level builds each output as an OR of interval terms. An interval term for the half-open count range [a, b) is the AND of "at least a" with the inverted "at least b".

The set of counts for which each output is high is a parameter, given as one bit per count per output. The interval endpoints are derived from that mask at elaboration time. The default parameters configure the block as a seven-input parallel counter with three count-bit outputs. The block is used wherever a popcount or another symmetric function is needed with a fixed, short latency. Examples are partial-product compression and majority or parity voting.

Both levels are clocked. A pattern presented with its strobe appears at the outputs, with a matching strobe, two rising edges later.

Top module: `sym_func_unit`

## Requirements
- R1: While reset is asserted, and until the first strobed result emerges, `out_valid` is 0 and `out_bits` is all zeros.
- R2: `out_valid` rises exactly two rising clock edges after the edge that samples `in_valid` high. It stays low two edges after an edge that samples `in_valid` low.
- R3: Any two input patterns with the same number of ones produce identical `out_bits`.
- R4: In the default configuration, `out_bits[2]` is 1 exactly when the count of ones is in [4, 7].
- R5: In the default configuration, `out_bits[1]` is 1 exactly when the count is in [2, 4) or in [6, 7].
- R6: In the default configuration, `out_bits[0]` is 1 exactly when the count is odd (1, 3, 5 or 7).
- R7: The threshold bits form a thermometer code, and each is held together with its exact complement. As a result, the unsigned value of `out_bits` equals the count of ones in the default configuration.
- R8: For any count, at most one interval term per output is true. An interval touching count 0 or count N uses a single threshold. All-zero input gives all-zero outputs, and all-one input gives all-one outputs.
- R9: A count exactly equal to a threshold k resolves that threshold to 1 and never ties. Counts 2, 4 and 6 therefore land inside the intervals that start at them.
- R10: An edge that samples `in_valid` low leaves `out_bits` unchanged two edges later. Input data presented without the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Strobe qualifying `in_vec` |
| in_vec | input | N_IN (7) | Input bits whose count of ones is evaluated |
| out_valid | output | 1 | Strobe qualifying `out_bits`, two cycles after `in_valid` |
| out_bits | output | N_OUT (3) | Function outputs; bit j is output j, bit 0 least significant |

## Verification
A threshold detector stuck high or low, or one that loses its complement, corrupts outputs only for counts on one side of that threshold. Such a fault appears at `out_bits` two edges after the first pattern with an affected count. The bench therefore applies every pattern of the default configuration and compares each output bit against its own interval rule. A fault in the strobe pipeline or the enables shows up instead as a missing or extra `out_valid`, or as `out_bits` moving on an unstrobed cycle. The bench checks this on every cycle.

// File: rtl/symfn_pkg.sv
package symfn_pkg;

  localparam int MAX_ROW = 64;

  // One bit per count per output: bit (j*(n+1)+c) set when output j is high
  // for count c. The counter configuration sets it when bit j of c is one.
  function automatic logic [511:0] counter_onset(input int n, input int m);
    logic [511:0] r;
    r = '0;
    for (int j = 0; j < m; j++) begin
      for (int c = 0; c <= n; c++) begin
        r[j*(n+1)+c] = ((c >> j) & 1) != 0;
      end
    end
    return r;
  endfunction

  // True when count c opens an on-set interval of the row.
  function automatic bit opens_interval(input logic [MAX_ROW-1:0] row, input int c);
    if (!row[c]) return 1'b0;
    if (c == 0) return 1'b1;
    return !row[c-1];
  endfunction

  // First count above c that is off; n+1 when the interval runs to the top.
  function automatic int interval_stop(input logic [MAX_ROW-1:0] row, input int c,
                                       input int n);
    for (int e = c + 1; e <= n; e++) begin
      if (!row[e]) return e;
    end
    return n + 1;
  endfunction

endpackage

// File: rtl/symfn_rst_sync.sv
module symfn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/symfn_thresh_bank.sv
module symfn_thresh_bank #(
  parameter int N_IN = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [N_IN-1:0] in_vec,
  output logic [N_IN:1]   ge_q,
  output logic [N_IN:1]   ge_n_q
);
  localparam int CW = $clog2(N_IN + 1);

  logic [CW-1:0] ones_cnt;
  logic [N_IN:1] ge_d;
  logic [N_IN:1] ge_nx;
  logic [N_IN:1] ge_n_nx;

  always_comb begin
    ones_cnt = '0;
    for (int i = 0; i < N_IN; i++) begin
      ones_cnt = ones_cnt + CW'(in_vec[i]);
    end
  end

  // Each detector compares twice the count with 2k-1: equality cannot occur,
  // so a count equal to k always decides high.
  for (genvar k = 1; k <= N_IN; k++) begin : g_det
    localparam int BIAS2 = 2 * k - 1;
    assign ge_d[k] = (2 * int'(ones_cnt)) > BIAS2;

    AST_EQUAL_COUNT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (en && int'(ones_cnt) == k) |=> ge_q[k]); // R9
  end

  for (genvar k = 1; k < N_IN; k++) begin : g_order
    AST_THERMOMETER: assert property (@(posedge clk) disable iff (!rst_n)
      ge_q[k+1] |-> ge_q[k]); // R7
  end

  always_comb begin
    ge_nx   = ge_q;
    ge_n_nx = ge_n_q;
    if (en) begin
      ge_nx   = ge_d;
      ge_n_nx = ~ge_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ge_q   <= '0;
      ge_n_q <= '1;
    end else begin
      ge_q   <= ge_nx;
      ge_n_q <= ge_n_nx;
    end
  end

  AST_DUAL_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (ge_q ^ ge_n_q) == {N_IN{1'b1}}); // R7
endmodule

// File: rtl/symfn_interval_or.sv
module symfn_interval_or #(
  parameter int              N_IN      = 7,
  parameter logic [N_IN:0]   ONSET_ROW = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [N_IN:1] ge,
  input  logic [N_IN:1] ge_n,
  output logic          y_q
);
  import symfn_pkg::*;

  localparam logic [MAX_ROW-1:0] ROW64 = MAX_ROW'(ONSET_ROW);

  logic [N_IN:0] term;
  logic          y_d;
  logic          y_nx;

  for (genvar c = 0; c <= N_IN; c++) begin : g_term
    localparam bit OPENS = opens_interval(ROW64, c);
    localparam int STOP  = interval_stop(ROW64, c, N_IN);
    if (OPENS) begin : g_on
      logic lo_ok;
      logic hi_ok;
      if (c == 0) begin : g_lo_free
        assign lo_ok = 1'b1;
      end else begin : g_lo_thr
        assign lo_ok = ge[c];
      end
      if (STOP > N_IN) begin : g_hi_free
        assign hi_ok = 1'b1;
      end else begin : g_hi_thr
        assign hi_ok = ge_n[STOP];
      end
      assign term[c] = lo_ok & hi_ok;
    end else begin : g_off
      assign term[c] = 1'b0;
    end
  end

  assign y_d = |term;

  always_comb begin
    y_nx = y_q;
    if (en) begin
      y_nx = y_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= 1'b0;
    end else begin
      y_q <= y_nx;
    end
  end

  AST_ONE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(term)); // R8
  AST_ONSET_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (y_q == $past(ONSET_ROW[$countones(ge)]))); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(y_q)); // R10
endmodule

// File: rtl/sym_func_unit.sv
module sym_func_unit #(
  parameter int N_IN  = 7,
  parameter int N_OUT = 3,
  parameter logic [N_OUT*(N_IN+1)-1:0] ONSET =
    (N_OUT*(N_IN+1))'(symfn_pkg::counter_onset(N_IN, N_OUT))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [N_IN-1:0]  in_vec,
  output logic             out_valid,
  output logic [N_OUT-1:0] out_bits
);
  localparam int ROW_W = N_IN + 1;

  logic          rst_int_n;
  logic [N_IN:1] ge_q;
  logic [N_IN:1] ge_n_q;
  logic          stage1_vld_q;
  logic          stage2_vld_q;
  logic [1:0]    vld_nx;

  symfn_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  symfn_thresh_bank #(.N_IN(N_IN)) u_thresh (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en     (in_valid),
    .in_vec (in_vec),
    .ge_q   (ge_q),
    .ge_n_q (ge_n_q)
  );

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    symfn_interval_or #(
      .N_IN      (N_IN),
      .ONSET_ROW (ONSET[j*ROW_W +: ROW_W])
    ) u_or (
      .clk   (clk),
      .rst_n (rst_int_n),
      .en    (stage1_vld_q),
      .ge    (ge_q),
      .ge_n  (ge_n_q),
      .y_q   (out_bits[j])
    );
  end

  always_comb begin
    vld_nx = {stage1_vld_q, in_valid};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      stage1_vld_q <= 1'b0;
      stage2_vld_q <= 1'b0;
    end else begin
      stage1_vld_q <= vld_nx[0];
      stage2_vld_q <= vld_nx[1];
    end
  end

  assign out_valid = stage2_vld_q;

  AST_LATENCY_VALID: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |-> ##2 out_valid); // R2
  AST_LATENCY_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |-> ##2 !out_valid); // R2
endmodule

// File: tb/sym_func_unit_tb_top.sv
module sym_func_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [6:0] in_vec = '0;
  logic       out_valid;
  logic [2:0] out_bits;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;
  bit h0 = 1'b0;
  bit h1 = 1'b0;
  bit have_last = 1'b0;
  logic [2:0] last_bits = '0;
  int exp_q[$];
  logic [2:0] first_seen[8];
  bit seen[8];

  always #5 clk = ~clk;

  sym_func_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_vec    (in_vec),
    .out_valid (out_valid),
    .out_bits  (out_bits)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Driver: presents one item after an edge and queues its expected count.
  task automatic send(input logic [6:0] p, input bit v);
    @(posedge clk);
    #2;
    in_vec   = p;
    in_valid = v;
    if (v) exp_q.push_back($countones(p));
  endtask

  // Monitor: scores each result against the interval rules.
  always @(negedge clk) begin
    if (mon_on) begin
      bit exp_v;
      exp_v = h1;
      h1 = h0;
      h0 = in_valid;
      chk(out_valid == exp_v, "R2 out_valid latency", out_valid, exp_v);
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected result", 1, 0);
        end else begin
          int c;
          bit e2, e1, e0;
          c  = exp_q.pop_front();
          e2 = (c >= 4);
          e1 = (c >= 2 && c < 4) || (c >= 6);
          e0 = (c % 2) == 1;
          chk(out_bits[2] == e2, (c == 4) ? "R4 R9 msb at count 4" : "R4 msb",
              out_bits[2], e2);
          chk(out_bits[1] == e1, (c == 2 || c == 6) ? "R5 R9 mid at edge" : "R5 mid",
              out_bits[1], e1);
          chk(out_bits[0] == e0, "R6 lsb", out_bits[0], e0);
          chk(int'(out_bits) == c, "R7 count word", out_bits, c);
          if (c == 0 || c == 7)
            chk(out_bits == ((c == 7) ? 3'b111 : 3'b000), "R8 outer interval",
                out_bits, (c == 7) ? 7 : 0);
          if (seen[c]) begin
            chk(out_bits == first_seen[c], "R3 same count same result",
                out_bits, first_seen[c]);
          end else begin
            seen[c] = 1'b1;
            first_seen[c] = out_bits;
          end
          last_bits = out_bits;
          have_last = 1'b1;
        end
      end else if (have_last) begin
        chk(out_bits == last_bits, "R10 hold without strobe", out_bits, last_bits);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    chk(out_bits == 3'b000, "R1 bits in reset", out_bits, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #2;
    chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    chk(out_bits == 3'b000, "R1 bits after reset", out_bits, 0);
    @(negedge clk);
    mon_on = 1'b1;

    // Ascending thermometer patterns, counts 0..7
    for (int c = 0; c <= 7; c++) send(7'((1 << c) - 1), 1'b1);
    // Unstrobed data must not move the outputs (R10)
    send(7'h55, 1'b0);
    send(7'h7F, 1'b0);
    send(7'h01, 1'b0);
    // All 128 patterns, first permutation, with occasional gaps
    for (int i = 0; i < 128; i++) begin
      logic [6:0] p;
      p = 7'((i * 37 + 11) & 127);
      send(p, 1'b1);
      if (i % 9 == 4) send(~p, 1'b0);
    end
    // Second permutation, back to back
    for (int i = 0; i < 128; i++) send(7'((i * 91 + 5) & 127), 1'b1);
    send(7'h2A, 1'b0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    #1;
    chk(exp_q.size() == 0, "R2 all results delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule